// File: doc/BRIEF.md
# Correlating Two-Bit Branch Direction Predictor

This block guesses, for the fetch stage, whether a conditional branch will be taken. It holds a table of two-bit saturating counters. The table index combines the word address bits of the branch PC with a global shift register of recent branch outcomes. Because of this, a branch whose direction depends on the paths taken by earlier branches, such as an inner conditional nested in an outer one, gets a counter of its own for each recent path.

Fetch drives a PC and reads the prediction back in the same cycle. It also reads the history value that formed the index, and that value travels down the pipeline with the branch. When the branch resolves, the back end presents the branch PC, the carried history and the real outcome. The block then rebuilds the same index and moves that counter one step toward the outcome. In the same cycle it shifts the outcome into the global history.

Top module: `bp_correlating`

## Requirements
- R1: After reset every counter holds weakly not-taken (01), so every lookup predicts not-taken, and the global history reads zero.
- R2: The table index is fetch_pc[IDX_W+1:2] XOR the zero-extended global history. PC bits [1:0] and every PC bit above IDX_W+1 have no effect on the lookup.
- R3: A resolve with res_taken=1 raises the addressed counter by one and holds it at 11 once it is there.
- R4: A resolve with res_taken=0 lowers the addressed counter by one and holds it at 00 once it is there.
- R5: pred_taken is the MSB of the addressed counter. A counter at 11 still predicts taken after one not-taken resolve and predicts not-taken only after the second one.
- R6: On each resolve the history becomes {old[HIST_LEN-2:0], res_taken} at the next clock edge. Without a resolve it holds. pred_hist shows the current history.
- R7: The update index is built from res_pc and res_hist as in R2, whatever the global history is at resolve time.
- R8: A lookup and an update of the same entry in one cycle return the counter value from before the update. The new value appears from the next cycle.
- R9: With res_valid low no counter changes: repeated lookups of one entry return the same prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | PC looked up this cycle |
| pred_taken | output | 1 | Predicted direction for fetch_pc (1 = taken) |
| pred_hist | output | HIST_LEN | Global history used for this lookup, carried with the branch |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | PC of the resolving branch |
| res_hist | input | HIST_LEN | History that was carried with the resolving branch |
| res_taken | input | 1 | Actual outcome of the resolving branch |

## Verification
pred_taken and pred_hist are combinational results of fetch_pc, so they belong to the same cycle as the lookup. A counter update or a history shift from a resolve shows up only from the cycle after the next rising edge. The bench drives each cycle's inputs on the falling edge, with the expected prediction and history taken from its model state before that cycle's resolve. It then applies the resolve to the model. A monitor compares the outputs 5 ns later, before the rising edge, so every comparison matches one cycle and cannot be skewed by where the update lands.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'b00,
    CTR_WEAK_NT   = 2'b01,
    CTR_WEAK_T    = 2'b10,
    CTR_STRONG_T  = 2'b11
  } ctr_t;

  // one saturating step of a direction counter toward the outcome
  function automatic ctr_t ctr_step(ctr_t cur, logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) nxt = ctr_t'(cur + 2'b01);
    end else begin
      if (cur != CTR_STRONG_NT) nxt = ctr_t'(cur - 2'b01);
    end
    return nxt;
  endfunction

endpackage

// File: rtl/bp_index_hash.sv
`timescale 1ns/1ps
module bp_index_hash #(
  parameter int IDX_W    = 12,
  parameter int HIST_LEN = 12
) (
  input  logic [IDX_W-1:0]    pc_word,
  input  logic [HIST_LEN-1:0] hist,
  output logic [IDX_W-1:0]    idx
);

  // the history is folded onto the low index bits when it is shorter
  always_comb begin
    idx = pc_word ^ IDX_W'(hist);
  end

endmodule

// File: rtl/bp_history_reg.sv
`timescale 1ns/1ps
module bp_history_reg #(
  parameter int HIST_LEN = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                bit_in,
  output logic [HIST_LEN-1:0] hist
);

  logic [HIST_LEN-1:0] hist_q;

  generate
    if (HIST_LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= bit_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_LEN-2:0], bit_in};
      end
    end
  endgenerate

  assign hist = hist_q;

endmodule

// File: rtl/bp_counter_table.sv
`timescale 1ns/1ps
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_taken,
  output ctr_t             upd_old
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];
  ctr_t upd_new;

  // both read ports are asynchronous, so a lookup sees the value before any write in its cycle
  always_comb begin
    rd_ctr  = mem[rd_idx];
    upd_old = mem[upd_idx];
    upd_new = ctr_step(upd_old, upd_taken);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_WEAK_NT;
    end else if (upd_en) begin
      mem[upd_idx] <= upd_new;
    end
  end

endmodule

// File: rtl/bp_correlating.sv
`timescale 1ns/1ps
module bp_correlating
  import bp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ENTRIES  = 4096,
  parameter int HIST_LEN = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PC_W-1:0]     fetch_pc,
  output logic                pred_taken,
  output logic [HIST_LEN-1:0] pred_hist,
  input  logic                res_valid,
  input  logic [PC_W-1:0]     res_pc,
  input  logic [HIST_LEN-1:0] res_hist,
  input  logic                res_taken
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int PC_LO = 2;
  localparam int PC_HI = IDX_W + PC_LO - 1;

  logic [HIST_LEN-1:0] ghist;
  logic [IDX_W-1:0]    fetch_idx;
  logic [IDX_W-1:0]    res_idx;
  ctr_t                fetch_ctr;
  ctr_t                res_ctr_old;

  // byte offset and upper PC bits take no part in indexing
  logic unused_pc_bits;
  assign unused_pc_bits = ^{fetch_pc[PC_LO-1:0], fetch_pc[PC_W-1:PC_HI+1],
                            res_pc[PC_LO-1:0],   res_pc[PC_W-1:PC_HI+1]};

  bp_history_reg #(.HIST_LEN(HIST_LEN)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .shift_en (res_valid),
    .bit_in   (res_taken),
    .hist     (ghist)
  );

  bp_index_hash #(.IDX_W(IDX_W), .HIST_LEN(HIST_LEN)) u_fetch_hash (
    .pc_word (fetch_pc[PC_HI:PC_LO]),
    .hist    (ghist),
    .idx     (fetch_idx)
  );

  bp_index_hash #(.IDX_W(IDX_W), .HIST_LEN(HIST_LEN)) u_res_hash (
    .pc_word (res_pc[PC_HI:PC_LO]),
    .hist    (res_hist),
    .idx     (res_idx)
  );

  bp_counter_table #(.IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (fetch_idx),
    .rd_ctr    (fetch_ctr),
    .upd_en    (res_valid),
    .upd_idx   (res_idx),
    .upd_taken (res_taken),
    .upd_old   (res_ctr_old)
  );

  assign pred_taken = fetch_ctr[1];
  assign pred_hist  = ghist;

endmodule

// File: rtl/bp_correlating_chk.sv
`timescale 1ns/1ps
module bp_correlating_chk #(
  parameter int PC_W     = 32,
  parameter int HIST_LEN = 12,
  parameter int IDX_W    = 12
) (
  input logic                clk,
  input logic                rst,
  input logic [PC_W-1:0]     fetch_pc,
  input logic                pred_taken,
  input logic [HIST_LEN-1:0] pred_hist,
  input logic                res_valid,
  input logic                res_taken,
  input logic [IDX_W-1:0]    fetch_idx,
  input logic [IDX_W-1:0]    res_idx,
  input logic [1:0]          res_ctr_old
);

  // R1
  hist_clear_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pred_hist == '0);

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> pred_hist == {$past(pred_hist[HIST_LEN-2:0]), $past(res_taken)});

  // R6
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |=> $stable(pred_hist));

  // R3
  taken_moves_up_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_taken && res_ctr_old != 2'b00) ##1 (fetch_idx == $past(res_idx))
    |-> pred_taken);

  // R4
  not_taken_moves_down_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_taken && res_ctr_old != 2'b11) ##1 (fetch_idx == $past(res_idx))
    |-> !pred_taken);

  // R9
  idle_table_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid ##1 $stable(fetch_pc) |-> $stable(pred_taken));

endmodule

bind bp_correlating bp_correlating_chk #(
  .PC_W(PC_W), .HIST_LEN(HIST_LEN), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fetch_pc    (fetch_pc),
  .pred_taken  (pred_taken),
  .pred_hist   (pred_hist),
  .res_valid   (res_valid),
  .res_taken   (res_taken),
  .fetch_idx   (fetch_idx),
  .res_idx     (res_idx),
  .res_ctr_old (res_ctr_old)
);

// File: tb/sim_bp_correlating.sv
`timescale 1ns/1ps
module sim_bp_correlating;

  localparam int PC_W = 32;
  localparam int ENTRIES = 4096;
  localparam int HL = 12;
  localparam int IW = 12;

  typedef struct {
    logic          pred;
    logic [HL-1:0] hist;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred_taken;
  logic [HL-1:0]   pred_hist;
  logic            res_valid = 1'b0;
  logic [PC_W-1:0] res_pc = '0;
  logic [HL-1:0]   res_hist = '0;
  logic            res_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  exp_t q[$];
  logic [1:0]    mdl_tab [ENTRIES];
  logic [HL-1:0] mdl_hist;

  always #10 clk = ~clk;

  bp_correlating #(.PC_W(PC_W), .ENTRIES(ENTRIES), .HIST_LEN(HL)) u0 (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .res_valid(res_valid), .res_pc(res_pc),
    .res_hist(res_hist), .res_taken(res_taken)
  );

  // fetch PC that lands on table entry idx under the current history (R2)
  function automatic logic [PC_W-1:0] pc_of(input logic [IW-1:0] idx,
                                            input logic [1:0] lo,
                                            input logic [17:0] hi);
    return {hi, idx ^ mdl_hist, lo};
  endfunction

  // resolve PC that lands on entry idx when carried history is h (R7)
  function automatic logic [PC_W-1:0] rpc_of(input logic [IW-1:0] idx,
                                             input logic [HL-1:0] h);
    return {18'h0, idx ^ h, 2'b00};
  endfunction

  task automatic cyc(input logic [PC_W-1:0] pc, input logic rv,
                     input logic [PC_W-1:0] rpc, input logic [HL-1:0] rh,
                     input logic rt, input string tag);
    exp_t e;
    logic [IW-1:0] fi;
    logic [IW-1:0] ri;
    @(negedge clk);
    fetch_pc  = pc;
    res_valid = rv;
    res_pc    = rpc;
    res_hist  = rh;
    res_taken = rt;
    fi = pc[IW+1:2] ^ mdl_hist;
    e.pred = mdl_tab[fi][1];
    e.hist = mdl_hist;
    e.tag  = tag;
    q.push_back(e);
    if (rv) begin
      ri = rpc[IW+1:2] ^ rh;
      if (rt && mdl_tab[ri] != 2'b11) mdl_tab[ri] = mdl_tab[ri] + 2'b01;
      if (!rt && mdl_tab[ri] != 2'b00) mdl_tab[ri] = mdl_tab[ri] - 2'b01;
      mdl_hist = {mdl_hist[HL-2:0], rt};
    end
  endtask

  task automatic probe(input logic [IW-1:0] idx, input logic [1:0] lo,
                       input logic [17:0] hi, input string tag);
    cyc(pc_of(idx, lo, hi), 1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic train(input logic [IW-1:0] idx, input logic [HL-1:0] h,
                       input logic t, input string tag);
    cyc(pc_of(12'h000, 2'b00, 18'h0), 1'b1, rpc_of(idx, h), h, t, tag);
  endtask

  // monitor: compare each cycle's outputs before the next rising edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (pred_taken !== e.pred || pred_hist !== e.hist) begin
          errors++;
          $display("FAIL %s: pred=%0b hist=%03h expected pred=%0b hist=%03h",
                   e.tag, pred_taken, pred_hist, e.pred, e.hist);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) mdl_tab[i] = 2'b01;
    mdl_hist = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state, all weakly not-taken, history zero
    cyc(32'h0000_0000, 0, '0, '0, 0, "R1 reset pc0");
    cyc(32'h0000_3ffc, 0, '0, '0, 0, "R1 reset top entry");
    cyc(32'hdead_beef, 0, '0, '0, 0, "R1 reset high pc");

    // R3: taken updates saturate at 11
    for (int k = 0; k < 4; k++) train(12'h155, 12'h0aa, 1, "R3 train taken");
    probe(12'h155, 2'b00, 18'h0, "R3 saturated high");
    // R2: low and high PC bits ignored
    probe(12'h155, 2'b11, 18'h0, "R2 byte offset ignored");
    probe(12'h155, 2'b01, 18'h2_a5a5, "R2 upper bits ignored");
    probe(12'h154, 2'b00, 18'h0, "R2 neighbour untouched");

    // R4: not-taken updates saturate at 00, then one taken stays not-taken
    for (int k = 0; k < 4; k++) train(12'h2c3, 12'h011, 0, "R4 train not-taken");
    train(12'h2c3, 12'h011, 1, "R4 one taken from floor");
    probe(12'h2c3, 2'b00, 18'h0, "R4 floor still not-taken");

    // R5: strong taken needs two not-taken to flip
    for (int k = 0; k < 3; k++) train(12'h0f0, 12'h3c3, 1, "R5 train strong");
    train(12'h0f0, 12'h3c3, 0, "R5 first miss");
    probe(12'h0f0, 2'b00, 18'h0, "R5 still taken after one miss");
    train(12'h0f0, 12'h3c3, 0, "R5 second miss");
    probe(12'h0f0, 2'b00, 18'h0, "R5 flipped after two misses");

    // R7: update uses carried history, not live history
    train(12'h777, 12'hfff, 1, "R7 carried history a");
    train(12'h777, 12'h000, 1, "R7 carried history b");
    probe(12'h777, 2'b00, 18'h0, "R7 entry from res_pc^res_hist");

    // R8: same-cycle lookup sees the old value, next cycle the new one
    cyc(pc_of(12'h5a5, 2'b00, 18'h0), 1'b1, rpc_of(12'h5a5, 12'h123), 12'h123, 1'b1,
        "R8 same cycle old value");
    probe(12'h5a5, 2'b00, 18'h0, "R8 next cycle new value");

    // R9 and R6: idle cycles change neither table nor history
    for (int k = 0; k < 4; k++) probe(12'h155, 2'b00, 18'h0, "R9 idle hold");

    // R6 with mixed traffic: history checked on every cycle
    for (int k = 0; k < 400; k++) begin
      logic [HL-1:0] h;
      h = HL'($urandom_range(0, 15));
      cyc({18'h0, IW'($urandom_range(0, 31)), 2'($urandom)}, 1'($urandom),
          {18'h0, IW'($urandom_range(0, 31)), 2'b00}, h, 1'($urandom),
          "R6 mixed traffic");
    end

    repeat (3) @(negedge clk);
    #6;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule